// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a memory-mapped GPIO controller built from a parameterised number of 8-pin ports. Software reaches it over a simple 32-bit register bus. A global control register at address 0 switches the block on and off, and it also reports a fixed version number and the number of ports. Each port has its own group of eight word registers. Port `p` has its group at byte address `(p + 1) * 64`. Pin `k` of port `p` is global pin `p * 8 + k`, so the low three bits of a global pin number select the pin within its port.

Each pin can be an input or a push-pull output, and each has a pull-up that software can disable. Pin inputs pass through a two-flop synchronizer. An edge detector compares the synchronized value with its value one cycle earlier. A selected edge latches an event bit. Software clears an event bit by writing 1 to it. Each port drives its own interrupt line from its pending, enabled events, and software can also force that line high. While the block is switched off, every register keeps its value, no new event is latched, and all pad and interrupt outputs hold their last value.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous reset, all pad outputs, output enables and pull-up enables are 0 and all interrupt lines are 0. The block is off. The output data, mode, interrupt enable, edge select, event and force registers read 0, and the pull register reads 0xFF.
- R2: The control register is at byte address 0x000. Port p's register group starts at (p+1)*0x40, with word offsets 0x00 input, 0x04 output data, 0x08 mode, 0x0C pull, 0x10 interrupt enable, 0x14 edge select, 0x18 event and 0x1C force. Any address that maps to no register reads 0.
- R3: The mode register holds 2 bits per pin, at bits 2k+1:2k. The code 00 makes pin k an input. Any other code drives pad_oe for that pin high, one cycle after the write takes effect.
- R4: Bit k of the output data register appears on pad_out for pin k, one cycle after the write takes effect.
- R5: In the pull register a 1 disables the pull-up. pad_pu_en for pin k is the inverse of bit k, one cycle after the write takes effect.
- R6: Reading the input register returns the pad levels delayed by the two-flop synchronizer. A pad change driven before clock edge k is readable after edge k+1.
- R7: An edge-select bit of 1 latches an event on a rising synchronized edge, and 0 latches one on a falling edge. The event bit is set at clock edge k+2 for a pad change before edge k. An edge of the other polarity latches nothing.
- R8: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. When a clear and a new edge on the same pin land on the same clock edge, the event stays set.
- R9: A port's interrupt line is registered. It goes high one cycle after any event bit whose interrupt enable bit is 1 is set. Events on pins with the enable bit at 0 are latched but do not raise the line.
- R10: Bit 0 of a port's force register raises that port's interrupt line one cycle after it is set. Writing 0 to the register removes the forced level.
- R11: The control register reads the version in bits 15:9 and the port count in bits 8:2. Both fields are read-only. Bit 0 is the block-on bit and can be written.
- R12: While bit 0 of the control register is 0, no event bit is set, and pad_out, pad_oe, pad_pu_en and the interrupt lines hold their values. Register writes still land and can be read back. The outputs take the stored values one cycle after the block is switched on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read (qualified by bus_sel) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | NUM_PORTS*8 | Pad input levels, global pin order |
| pad_out | output | NUM_PORTS*8 | Pad output levels |
| pad_oe | output | NUM_PORTS*8 | Pad output enables |
| pad_pu_en | output | NUM_PORTS*8 | Pull-up enables |
| irq | output | NUM_PORTS | One interrupt line per port |

## Verification
Register writes take effect at the clock edge that samples them, and a pad output follows one edge after that. A pad input change becomes readable after two edges and latches an event on the third edge. The port's interrupt line follows on the fourth edge. A behavioural model in the bench advances on the same edges, and all outputs are compared 3 ns after every rising edge, so each result is checked in exactly the cycle it is due. The directed checks wait at least the number of edges listed above before they sample. The same-edge clear-and-set case is driven by placing the write on the exact edge at which the event is due.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PIN_CNT     = 8;
    localparam int DATA_W      = 32;
    localparam int STRIDE_LOG2 = 6;
    localparam int OFS_W       = STRIDE_LOG2 - 2;
    localparam int WR_W        = 2 * PIN_CNT;
    localparam int FIELD_W     = 7;

    typedef logic [PIN_CNT-1:0] pin_vec_t;
    typedef logic [WR_W-1:0]    mode_vec_t;

    typedef enum logic [OFS_W-1:0] {
        OFS_IN   = 4'd0,
        OFS_OUT  = 4'd1,
        OFS_MODE = 4'd2,
        OFS_PULL = 4'd3,
        OFS_IEN  = 4'd4,
        OFS_EDGE = 4'd5,
        OFS_EVT  = 4'd6,
        OFS_FRC  = 4'd7
    } port_reg_e;

    typedef struct packed {
        logic      wr_en;
        port_reg_e sel;
        mode_vec_t wdata;
    } port_wr_t;

    typedef struct packed {
        pin_vec_t out;
        pin_vec_t oe;
        pin_vec_t pu_en;
    } pad_drive_t;

    function automatic pin_vec_t mode_to_oe(mode_vec_t m);
        pin_vec_t oe;
        for (int i = 0; i < PIN_CNT; i++) begin
            oe[i] = |m[2*i +: 2];
        end
        return oe;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] sync,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] meta_q, stab_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    assign sync = stab_q;
    assign rise = stab_q & ~prev_q;
    assign fall = ~stab_q & prev_q;
endmodule

// File: rtl/gpio_port_unit.sv
module gpio_port_unit
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              blk_on,
    input  port_wr_t          wr,
    input  port_reg_e         rd_sel,
    input  pin_vec_t          pin_in,
    output logic [DATA_W-1:0] rd_data,
    output pad_drive_t        pad,
    output logic              irq,
    output logic              frc_q,
    output pin_vec_t          evt_q
);
    pin_vec_t  sync_v, rise_v, fall_v, hit_v, evt_d;
    pin_vec_t  out_q, pull_q, ien_q, edge_q;
    mode_vec_t mode_q;

    gpio_pin_sync #(.WIDTH(PIN_CNT)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .sync (sync_v),
        .rise (rise_v),
        .fall (fall_v)
    );

    assign hit_v = (edge_q & rise_v) | (~edge_q & fall_v);

    always_comb begin
        evt_d = evt_q;
        if (wr.wr_en && wr.sel == OFS_EVT) begin
            evt_d = evt_d & ~wr.wdata[PIN_CNT-1:0];
        end
        if (blk_on) begin
            evt_d = evt_d | hit_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            mode_q <= '0;
            pull_q <= '1;
            ien_q  <= '0;
            edge_q <= '0;
            evt_q  <= '0;
            frc_q  <= 1'b0;
            pad    <= '0;
            irq    <= 1'b0;
        end else begin
            if (wr.wr_en) begin
                case (wr.sel)
                    OFS_OUT:  out_q  <= wr.wdata[PIN_CNT-1:0];
                    OFS_MODE: mode_q <= wr.wdata;
                    OFS_PULL: pull_q <= wr.wdata[PIN_CNT-1:0];
                    OFS_IEN:  ien_q  <= wr.wdata[PIN_CNT-1:0];
                    OFS_EDGE: edge_q <= wr.wdata[PIN_CNT-1:0];
                    OFS_FRC:  frc_q  <= wr.wdata[0];
                    default:  ;
                endcase
            end
            evt_q <= evt_d;
            if (blk_on) begin
                pad.out   <= out_q;
                pad.oe    <= mode_to_oe(mode_q);
                pad.pu_en <= ~pull_q;
                irq       <= frc_q | (|(evt_q & ien_q));
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            OFS_IN:   rd_data = DATA_W'(sync_v);
            OFS_OUT:  rd_data = DATA_W'(out_q);
            OFS_MODE: rd_data = DATA_W'(mode_q);
            OFS_PULL: rd_data = DATA_W'(pull_q);
            OFS_IEN:  rd_data = DATA_W'(ien_q);
            OFS_EDGE: rd_data = DATA_W'(edge_q);
            OFS_EVT:  rd_data = DATA_W'(evt_q);
            OFS_FRC:  rd_data = DATA_W'(frc_q);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int         NUM_PORTS = 3,
    parameter int         ADDR_W    = 10,
    parameter logic [6:0] VERSION   = 7'd5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [NUM_PORTS*PIN_CNT-1:0] pad_in,
    output logic [NUM_PORTS*PIN_CNT-1:0] pad_out,
    output logic [NUM_PORTS*PIN_CNT-1:0] pad_oe,
    output logic [NUM_PORTS*PIN_CNT-1:0] pad_pu_en,
    output logic [NUM_PORTS-1:0]         irq
);
    localparam int PF_W = ADDR_W - STRIDE_LOG2;

    logic [PF_W-1:0]  pfield;
    port_reg_e        reg_sel;
    logic             wr_any, ctrl_hit, blk_on;
    logic [NUM_PORTS-1:0]         port_hit, frc_vec;
    logic [NUM_PORTS*PIN_CNT-1:0] evt_flat;
    logic [DATA_W-1:0]            port_rd [NUM_PORTS];
    logic [17:0]                  unused_bits;

    assign pfield      = bus_addr[ADDR_W-1:STRIDE_LOG2];
    assign reg_sel     = port_reg_e'(bus_addr[STRIDE_LOG2-1:2]);
    assign wr_any      = bus_sel & bus_wr;
    assign ctrl_hit    = (pfield == '0) && (bus_addr[STRIDE_LOG2-1:2] == '0);
    assign unused_bits = {bus_addr[1:0], bus_wdata[31:16]};

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_on <= 1'b0;
        end else if (wr_any && ctrl_hit) begin
            blk_on <= bus_wdata[0];
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_wr_t   wr_req;
        pad_drive_t drv;

        assign port_hit[p]    = (pfield == PF_W'(p + 1));
        assign wr_req.wr_en   = wr_any & port_hit[p];
        assign wr_req.sel     = reg_sel;
        assign wr_req.wdata   = bus_wdata[WR_W-1:0];

        gpio_port_unit u_port (
            .clk     (clk),
            .rst     (rst),
            .blk_on  (blk_on),
            .wr      (wr_req),
            .rd_sel  (reg_sel),
            .pin_in  (pad_in[p*PIN_CNT +: PIN_CNT]),
            .rd_data (port_rd[p]),
            .pad     (drv),
            .irq     (irq[p]),
            .frc_q   (frc_vec[p]),
            .evt_q   (evt_flat[p*PIN_CNT +: PIN_CNT])
        );

        assign pad_out[p*PIN_CNT +: PIN_CNT]   = drv.out;
        assign pad_oe[p*PIN_CNT +: PIN_CNT]    = drv.oe;
        assign pad_pu_en[p*PIN_CNT +: PIN_CNT] = drv.pu_en;
    end

    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit) begin
            bus_rdata = {16'h0, VERSION, FIELD_W'(NUM_PORTS), 1'b0, blk_on};
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_hit[p]) begin
                bus_rdata = bus_rdata | port_rd[p];
            end
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl_sva.sv
module gpio_bank_ctrl_sva #(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 10
) (
    input logic                   clk,
    input logic                   rst,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [31:0]            bus_rdata,
    input logic [NUM_PORTS*8-1:0] pad_out,
    input logic [NUM_PORTS*8-1:0] pad_oe,
    input logic [NUM_PORTS-1:0]   irq,
    input logic                   blk_on,
    input logic [NUM_PORTS-1:0]   frc_vec,
    input logic [NUM_PORTS*8-1:0] evt_flat
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq == '0 && pad_oe == '0 && pad_out == '0)); // R1

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(blk_on)) |-> ($stable(pad_out) && $stable(pad_oe) && $stable(irq))); // R12

    AST_NO_EVENT_OFF: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(blk_on)) |-> ((evt_flat & ~$past(evt_flat)) == '0)); // R12

    AST_FORCE_IRQ: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(blk_on)) |-> ((irq & $past(frc_vec)) == $past(frc_vec))); // R10

    AST_CTRL_COUNT: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == '0) |-> (bus_rdata[8:2] == 7'(NUM_PORTS))); // R11
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_sva #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .blk_on    (blk_on),
    .frc_vec   (frc_vec),
    .evt_flat  (evt_flat)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;
    localparam int NP = 3;
    localparam int AW = 10;
    localparam int NW = NP * 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NW-1:0] pad_in = '0;
    logic [NW-1:0] pad_out, pad_oe, pad_pu_en;
    logic [NP-1:0] irq;

    int n_vec = 0;
    int n_bad = 0;
    bit armed = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PORTS(NP), .ADDR_W(AW), .VERSION(7'd5)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu_en(pad_pu_en), .irq(irq)
    );

    // behavioural reference state
    bit [7:0]  m_s1 [NP], m_s2 [NP], m_s3 [NP];
    bit [7:0]  m_out [NP], m_pull [NP], m_ien [NP], m_edge [NP], m_evt [NP];
    bit [15:0] m_mode [NP];
    bit        m_frc [NP];
    bit [7:0]  m_pout [NP], m_poe [NP], m_ppu [NP];
    bit        m_irq [NP];
    bit        m_on;

    function automatic int port_of(logic [AW-1:0] a);
        return int'(a) / 64 - 1;
    endfunction
    function automatic int ofs_of(logic [AW-1:0] a);
        return (int'(a) % 64) / 4;
    endfunction

    function automatic logic [31:0] model_read(logic [AW-1:0] a);
        int p = port_of(a);
        int o = ofs_of(a);
        if (p == -1) return (o == 0) ? ((32'd5 << 9) | (32'(NP) << 2) | 32'(m_on)) : 32'h0;
        if (p >= NP) return 32'h0;
        case (o)
            0: return 32'(m_s2[p]);
            1: return 32'(m_out[p]);
            2: return 32'(m_mode[p]);
            3: return 32'(m_pull[p]);
            4: return 32'(m_ien[p]);
            5: return 32'(m_edge[p]);
            6: return 32'(m_evt[p]);
            7: return 32'(m_frc[p]);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit wnow;
        int wp, wo;
        bit [7:0] nev, fire;
        wnow = bus_sel && bus_wr;
        wp = port_of(bus_addr);
        wo = ofs_of(bus_addr);
        if (rst) begin
            armed = 1'b1;
            m_on = 1'b0;
            for (int p = 0; p < NP; p++) begin
                m_s1[p] = 0; m_s2[p] = 0; m_s3[p] = 0;
                m_out[p] = 0; m_pull[p] = 8'hFF; m_ien[p] = 0; m_edge[p] = 0;
                m_evt[p] = 0; m_mode[p] = 0; m_frc[p] = 0;
                m_pout[p] = 0; m_poe[p] = 0; m_ppu[p] = 0; m_irq[p] = 0;
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (m_on) begin
                    m_pout[p] = m_out[p];
                    for (int i = 0; i < 8; i++) m_poe[p][i] = m_mode[p][2*i] | m_mode[p][2*i+1];
                    m_ppu[p] = ~m_pull[p];
                    m_irq[p] = m_frc[p] || ((m_evt[p] & m_ien[p]) != 0);
                end
                for (int i = 0; i < 8; i++)
                    fire[i] = m_edge[p][i] ? (m_s2[p][i] && !m_s3[p][i]) : (!m_s2[p][i] && m_s3[p][i]);
                nev = m_evt[p];
                if (wnow && wp == p && wo == 6) nev = nev & ~bus_wdata[7:0];
                if (m_on) nev = nev | fire;
                m_evt[p] = nev;
                m_s3[p] = m_s2[p];
                m_s2[p] = m_s1[p];
                m_s1[p] = pad_in[p*8 +: 8];
                if (wnow && wp == p) begin
                    case (wo)
                        1: m_out[p]  = bus_wdata[7:0];
                        2: m_mode[p] = bus_wdata[15:0];
                        3: m_pull[p] = bus_wdata[7:0];
                        4: m_ien[p]  = bus_wdata[7:0];
                        5: m_edge[p] = bus_wdata[7:0];
                        7: m_frc[p]  = bus_wdata[0];
                        default: ;
                    endcase
                end
            end
            if (wnow && wp == -1 && wo == 0) m_on = bus_wdata[0];
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rd_tag(logic [AW-1:0] a);
        int o = ofs_of(a);
        if (port_of(a) == -1) return "R11 ctrl read";
        case (o)
            0: return "R6 input read";
            1: return "R4 out read";
            2: return "R3 mode read";
            3: return "R5 pull read";
            4: return "R9 ien read";
            5: return "R7 edge read";
            6: return "R8 event read";
            7: return "R10 force read";
            default: return "R2 unmapped read";
        endcase
    endfunction

    // per-cycle comparison against the model, 3 ns after each rising edge
    always @(posedge clk) begin
        #3;
        if (armed && !finished) begin
            logic [NW-1:0] eo, eoe, epu;
            logic [NP-1:0] ei;
            for (int p = 0; p < NP; p++) begin
                eo[p*8 +: 8] = m_pout[p];
                eoe[p*8 +: 8] = m_poe[p];
                epu[p*8 +: 8] = m_ppu[p];
                ei[p] = m_irq[p];
            end
            chk("R4 pad_out", 32'(pad_out), 32'(eo));
            chk("R3 pad_oe", 32'(pad_oe), 32'(eoe));
            chk("R5 pad_pu_en", 32'(pad_pu_en), 32'(epu));
            chk("R9 irq", 32'(irq), 32'(ei));
            chk(rd_tag(bus_addr), bus_rdata, model_read(bus_addr));
        end
    end

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [AW-1:0] ra(int p, int o);
        return AW'((p + 1) * 64 + o);
    endfunction

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        idle(3);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 pad_oe reset", 32'(pad_oe), 32'h0);
        chk("R1 irq reset", 32'(irq), 32'h0);
        rd(ra(2, 'h1C), d); chk("R1 force reset", d, 32'h0);
        rd(ra(0, 'h0C), d); chk("R1 pull reset", d, 32'hFF);
        // R11 control register fields, block off
        rd(AW'(0), d); chk("R11 ctrl after reset", d, 32'h0000_0A0C);
        wr(AW'(0), 32'hFFFF_FFFF);
        rd(AW'(0), d); chk("R11 ctrl read-only fields", d, 32'h0000_0A0D);
        // R3 R4 mode and output data on port 1
        wr(ra(1, 'h08), 32'h0000_0039);
        wr(ra(1, 'h04), 32'h0000_00A5);
        idle(2);
        chk("R3 pad_oe port1", 32'(pad_oe[15:8]), 32'h07);
        chk("R4 pad_out port1", 32'(pad_out[15:8]), 32'hA5);
        // R2 map: no aliasing between ports, unmapped offset reads 0
        rd(ra(2, 'h04), d); chk("R2 port2 out untouched", d, 32'h0);
        rd(ra(1, 'h04), d); chk("R2 port1 out", d, 32'hA5);
        rd(ra(1, 'h20), d); chk("R2 unmapped offset", d, 32'h0);
        // R5 pull polarity
        wr(ra(0, 'h0C), 32'h0F);
        idle(2);
        chk("R5 pad_pu_en port0", 32'(pad_pu_en[7:0]), 32'hF0);
        // R6 synchronized input
        @(negedge clk); pad_in[23:16] = 8'h3C;
        idle(2);
        rd(ra(2, 'h00), d); chk("R6 input port2", d, 32'h3C);
        // R7 edge select on port 0: pin0 rising, pin1 falling
        wr(ra(0, 'h14), 32'h01);
        wr(ra(0, 'h10), 32'h03);
        @(negedge clk); pad_in[0] = 1'b1;
        idle(4);
        rd(ra(0, 'h18), d); chk("R7 rising event", d, 32'h01);
        @(negedge clk); pad_in[1] = 1'b1;
        idle(4);
        rd(ra(0, 'h18), d); chk("R7 wrong polarity ignored", d, 32'h01);
        @(negedge clk); pad_in[1] = 1'b0;
        idle(4);
        rd(ra(0, 'h18), d); chk("R7 falling event", d, 32'h03);
        chk("R9 irq port0 raised", 32'(irq[0]), 32'h1);
        // R8 write-one-to-clear
        wr(ra(0, 'h18), 32'h01);
        rd(ra(0, 'h18), d); chk("R8 clear bit0 only", d, 32'h02);
        wr(ra(0, 'h18), 32'h02);
        idle(2);
        rd(ra(0, 'h18), d); chk("R8 all cleared", d, 32'h0);
        chk("R9 irq port0 dropped", 32'(irq[0]), 32'h0);
        // R8 clear and new edge on the same clock edge: set wins
        @(negedge clk); pad_in[0] = 1'b0;
        idle(4);
        @(negedge clk); pad_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ra(0, 'h18); bus_wdata = 32'h01;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(ra(0, 'h18), d); chk("R8 set wins over clear", d, 32'h01);
        wr(ra(0, 'h18), 32'hFF);
        // R9 latched event on disabled pin does not raise irq
        wr(ra(0, 'h14), 32'h05);
        @(negedge clk); pad_in[2] = 1'b1;
        idle(4);
        rd(ra(0, 'h18), d); chk("R9 event latched on masked pin", d, 32'h04);
        chk("R9 masked pin no irq", 32'(irq[0]), 32'h0);
        // R10 force
        wr(ra(2, 'h1C), 32'h1);
        idle(1);
        chk("R10 force raises irq", 32'(irq[2]), 32'h1);
        wr(ra(2, 'h1C), 32'h0);
        idle(1);
        chk("R10 force released", 32'(irq[2]), 32'h0);
        // R12 block off: outputs hold, no events, writes land
        wr(AW'(0), 32'h0);
        wr(ra(1, 'h04), 32'h5A);
        wr(ra(0, 'h18), 32'hFF);
        @(negedge clk); pad_in[0] = 1'b0;
        idle(4);
        @(negedge clk); pad_in[0] = 1'b1;
        idle(4);
        chk("R12 pad_out holds", 32'(pad_out[15:8]), 32'hA5);
        rd(ra(1, 'h04), d); chk("R12 write landed", d, 32'h5A);
        rd(ra(0, 'h18), d); chk("R12 no event while off", d, 32'h0);
        wr(AW'(0), 32'h1);
        idle(1);
        chk("R12 outputs resume", 32'(pad_out[15:8]), 32'h5A);
        idle(4);
        finish_run();
    end
endmodule